// File: doc/BRIEF.md
# Completion Segmenter by Payload Size

This block sits on the completer side of a serial link. It accepts one read request at a time, given as a starting byte address, a byte length and a tag. It then issues a run of completion descriptors that together cover the whole range. Each descriptor carries the tag, the low seven bits of the address where that completion starts, the number of bytes still outstanding including that completion, and the number of payload bytes in that completion.

The payload of every completion is capped by a limit chosen with a 3-bit size code. Completion breaks are placed on 128-byte boundaries, so only the first piece of a misaligned request comes out short. This cap on payload is separate from any cap on how large a read request may be. Data fetch, header assembly and ordering between tags are left to neighbouring blocks.

One descriptor can leave per clock. The block takes a new request only after the last descriptor of the previous one has been consumed.

Top module: `cpl_segmenter`

## Requirements
- R1: After reset, `req_ready` is 1 and `cpl_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. On the next cycle `cpl_valid` is 1, with the request's tag and with `cpl_byte_cnt` equal to the request length.
- R3: The size code gives a payload limit of 128 << code bytes for codes 0 to 5 (0 = 128, 1 = 256, up to 5 = 4096). Codes 6 and 7 give 4096.
- R4: Let `cur` be the address where a completion starts. Its payload length is the smaller of (limit − (cur mod 128)) and the bytes outstanding. It never exceeds the limit.
- R5: Every completion except the last ends on a 128-byte boundary: (lower address + payload length) mod 128 = 0.
- R6: `cpl_byte_cnt` is the number of bytes outstanding including the current completion. Each accepted non-final descriptor reduces it by its payload length. The final descriptor's count equals its own payload length.
- R7: `cpl_lower_addr` holds bits 6:0 of the starting byte address of that completion.
- R8: `req_ready` is 0 from the cycle after acceptance until the last descriptor is taken, and 1 again on the next cycle. Requests presented in between are ignored.
- R9: A zero-length request yields exactly one descriptor, with payload 0 and byte count 0.
- R10: While `cpl_valid` is 1 and `cpl_ready` is 0, every descriptor field stays unchanged.
- R11: The size code is captured when the request is accepted. Later changes to it do not affect that request.
- R12: An aligned 4096-byte read with code 1 yields 16 completions of 256 bytes each. An aligned 512-byte read with code 1 yields 2 completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Starting byte address of the read |
| req_len | input | LEN_W | Read length in bytes |
| req_tag | input | TAG_W | Request tag |
| mps_code | input | 3 | Payload size code |
| cpl_valid | output | 1 | Descriptor present |
| cpl_ready | input | 1 | Consumer takes the descriptor |
| cpl_tag | output | TAG_W | Tag of the request being served |
| cpl_lower_addr | output | 7 | Low address bits of this completion's start |
| cpl_byte_cnt | output | LEN_W | Bytes outstanding including this completion |
| cpl_payload_len | output | LEN_W | Payload bytes in this completion |

## Verification
A corrupted current address or a stale captured size code shows up at once on the descriptor output. The lower-address field or the payload length of the very descriptor that follows goes wrong, and because the next start address is built from that length, the error carries into every later descriptor of the request. A wrong remaining count shows up in `cpl_byte_cnt` on the same cycle. It also changes where the run ends, so `req_ready` returns either one descriptor too early or too late. The bench sweeps every size code against a set of misaligned addresses and boundary lengths, with back-pressure, and compares every field of every descriptor against counts it works out itself.

// File: rtl/cseg_pkg.sv
package cseg_pkg;

  // completion boundary in bytes and its address bit count
  localparam int unsigned RCB_BYTES = 128;
  localparam int unsigned RCB_BITS  = 7;
  // largest size code that still doubles the limit
  localparam int unsigned TOP_CODE  = 5;

  // payload limit in bytes for a 3-bit size code
  function automatic int unsigned limit_bytes(input logic [2:0] code);
    int unsigned c;
    c = (int'(code) > TOP_CODE) ? TOP_CODE : int'(code);
    return RCB_BYTES << c;
  endfunction

endpackage

// File: rtl/cseg_limit.sv
module cseg_limit
  import cseg_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic [2:0]       code,
  output logic [LEN_W-1:0] limit
);

  assign limit = LEN_W'(limit_bytes(code));

endmodule

// File: rtl/cseg_chunk.sv
module cseg_chunk
  import cseg_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic [LEN_W-1:0]    rem,
  input  logic [RCB_BITS-1:0] addr_lo,
  input  logic [LEN_W-1:0]    limit,
  output logic [LEN_W-1:0]    size,
  output logic                last
);

  // bytes from the current address up to the limit-sized window end
  function automatic logic [LEN_W-1:0] room_of(input logic [LEN_W-1:0] lim,
                                               input logic [RCB_BITS-1:0] lo);
    return lim - LEN_W'(lo);
  endfunction

  logic [LEN_W-1:0] room;

  always_comb begin
    room = room_of(limit, addr_lo);
    last = (rem <= room);
    size = last ? rem : room;
  end

endmodule

// File: rtl/cseg_walker.sv
module cseg_walker
  import cseg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 13,
  parameter int TAG_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [TAG_W-1:0]    req_tag,
  input  logic [2:0]          mps_code,
  input  logic                take,
  input  logic [LEN_W-1:0]    step_size,
  input  logic                step_last,
  output logic                busy,
  output logic [2:0]          code_q,
  output logic [RCB_BITS-1:0] addr_lo,
  output logic [LEN_W-1:0]    rem,
  output logic [TAG_W-1:0]    tag_q
);

  logic [ADDR_W-1:0] cur_addr;
  logic              accept;
  logic              advance;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign advance   = busy && take;
  assign addr_lo   = cur_addr[RCB_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      rem      <= '0;
      tag_q    <= '0;
      code_q   <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      cur_addr <= req_addr;
      rem      <= req_len;
      tag_q    <= req_tag;
      code_q   <= mps_code;
    end else if (advance) begin
      if (step_last) begin
        busy <= 1'b0;
      end else begin
        cur_addr <= cur_addr + ADDR_W'(step_size);
        rem      <= rem - step_size;
      end
    end
  end

  // R11: captured code stays fixed for the whole request
  a_r11_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(advance && step_last) |=> $stable(code_q));

endmodule

// File: rtl/cpl_segmenter.sv
module cpl_segmenter
  import cseg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 13,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [2:0]        mps_code,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic [6:0]        cpl_lower_addr,
  output logic [LEN_W-1:0]  cpl_byte_cnt,
  output logic [LEN_W-1:0]  cpl_payload_len
);

  logic [2:0]          code_q;
  logic [RCB_BITS-1:0] addr_lo;
  logic [LEN_W-1:0]    rem;
  logic [LEN_W-1:0]    limit;
  logic [LEN_W-1:0]    step_size;
  logic                step_last;
  logic                busy;
  logic [TAG_W-1:0]    tag_q;

  cseg_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_tag   (req_tag),
    .mps_code  (mps_code),
    .take      (cpl_ready),
    .step_size (step_size),
    .step_last (step_last),
    .busy      (busy),
    .code_q    (code_q),
    .addr_lo   (addr_lo),
    .rem       (rem),
    .tag_q     (tag_q)
  );

  cseg_limit #(.LEN_W(LEN_W)) u_lim (
    .code  (code_q),
    .limit (limit)
  );

  cseg_chunk #(.LEN_W(LEN_W)) u_chunk (
    .rem     (rem),
    .addr_lo (addr_lo),
    .limit   (limit),
    .size    (step_size),
    .last    (step_last)
  );

  assign cpl_valid       = busy;
  assign cpl_tag         = tag_q;
  assign cpl_lower_addr  = addr_lo;
  assign cpl_byte_cnt    = rem;
  assign cpl_payload_len = step_size;

  // named events for the properties
  logic take_mid;
  assign take_mid = cpl_valid && cpl_ready && (cpl_payload_len != cpl_byte_cnt);

  // R2: first descriptor follows acceptance
  a_r2_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> cpl_valid && cpl_byte_cnt == $past(req_len)
                               && cpl_tag == $past(req_tag));

  // R4: payload within limit
  a_r4_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> cpl_payload_len <= limit);

  // R5: non-final completions end on the boundary
  a_r5_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_payload_len != cpl_byte_cnt
      |-> 7'(cpl_lower_addr + cpl_payload_len[6:0]) == 7'd0);

  // R6: count drops by the payload just taken
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    take_mid |=> cpl_valid && cpl_byte_cnt == $past(cpl_byte_cnt) - $past(cpl_payload_len));

  // R7: next lower address advances by the payload
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    take_mid |=> cpl_lower_addr == 7'($past(cpl_lower_addr) + $past(cpl_payload_len[6:0])));

  // R8: no new request while descriptors remain
  a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    take_mid |=> !req_ready);

  // R9: zero count means zero payload
  a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_byte_cnt == '0 |-> cpl_payload_len == '0);

  // R10: descriptor held under back-pressure
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_tag) && $stable(cpl_lower_addr)
                                && $stable(cpl_byte_cnt) && $stable(cpl_payload_len));

endmodule

// File: tb/cpl_segmenter_test.sv
`timescale 1ns/1ps
module cpl_segmenter_test;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 13;
  localparam int TAG_W  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic [TAG_W-1:0]  req_tag;
  logic [2:0]        mps_code;
  logic              cpl_valid;
  logic              cpl_ready;
  logic [TAG_W-1:0]  cpl_tag;
  logic [6:0]        cpl_lower_addr;
  logic [LEN_W-1:0]  cpl_byte_cnt;
  logic [LEN_W-1:0]  cpl_payload_len;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  cpl_segmenter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_tag(req_tag), .mps_code(mps_code),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_tag(cpl_tag),
    .cpl_lower_addr(cpl_lower_addr), .cpl_byte_cnt(cpl_byte_cnt),
    .cpl_payload_len(cpl_payload_len)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R3: limit from the size code, worked out by doubling
  function automatic int limit_for(input int code);
    int v = 128;
    for (int i = 0; i < code && i < 5; i++) v = v * 2;
    return v;
  endfunction

  task automatic run_req(input int addr, input int len, input int code, input int tag,
                         input int seed, output int pkts);
    int a    = addr;
    int left = len;
    int lim  = limit_for(code);
    int step = 0;
    bit done = 0;
    pkts = 0;
    @(negedge clk);
    chk("R8", "ready when idle", req_ready, 1);
    req_valid = 1; req_addr = ADDR_W'(addr); req_len = LEN_W'(len);
    req_tag = TAG_W'(tag); mps_code = 3'(code); cpl_ready = 0;
    @(negedge clk);
    // junk request and a new code while busy: both must be ignored (R8, R11)
    req_addr = ~ADDR_W'(addr); req_len = LEN_W'(7); req_tag = ~TAG_W'(tag);
    mps_code = 3'(code ^ 3);
    while (!done && pkts < 200) begin
      int win_end;
      int sz;
      bit last;
      bit stall;
      win_end = (a / 128) * 128 + lim;
      sz = win_end - a;
      if (sz > left) sz = left;
      last = (sz == left);
      chk("R2", "cpl_valid", cpl_valid, 1);
      chk("R8", "req_ready while busy", req_ready, 0);
      chk("R2", "tag", cpl_tag, tag & 8'hff);
      chk("R7", "lower address", cpl_lower_addr, a % 128);
      chk("R6", "byte count", cpl_byte_cnt, left);
      if (len == 0) chk("R9", "zero payload", cpl_payload_len, 0);
      else chk("R4 R5 R3 R11 R10", "payload length", cpl_payload_len, sz);
      stall = ((step * 5 + seed) % 4 == 0);
      step++;
      if (stall) begin
        cpl_ready = 0;
        @(negedge clk);
      end else begin
        cpl_ready = 1;
        if (last) req_valid = 0;
        @(negedge clk);
        cpl_ready = 0;
        pkts++;
        a = a + sz;
        left = left - sz;
        if (last) done = 1;
      end
    end
    chk("R8", "cpl_valid after last", cpl_valid, 0);
    chk("R8", "ready after last", req_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int addrs [8] = '{0, 1, 4, 64, 127, 128, 200, 4095};
    int lens  [12] = '{0, 1, 3, 127, 128, 129, 255, 256, 300, 512, 1000, 4096};
    int p;
    int tg = 0;
    rst_n = 0; req_valid = 0; req_addr = '0; req_len = '0; req_tag = '0;
    mps_code = '0; cpl_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ready in reset", req_ready, 1);
    chk("R1", "valid in reset", cpl_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "valid after reset", cpl_valid, 0);

    // R12: the two quoted cases
    run_req(0, 4096, 1, 5, 1, p);
    chk("R12", "packets 4096 at 256", p, 16);
    run_req(0, 512, 1, 6, 2, p);
    chk("R12", "packets 512 at 256", p, 2);
    // R3: clamp of the upper codes
    run_req(0, 4096, 5, 7, 3, p);
    chk("R3", "packets 4096 code 5", p, 1);
    run_req(0, 4096, 6, 8, 0, p);
    chk("R3", "packets 4096 code 6", p, 1);
    run_req(0, 4096, 7, 9, 1, p);
    chk("R3", "packets 4096 code 7", p, 1);
    run_req(0, 4096, 0, 10, 2, p);
    chk("R3", "packets 4096 code 0", p, 32);
    // R9: zero length gives a single descriptor
    run_req(77, 0, 2, 11, 3, p);
    chk("R9", "packets zero length", p, 1);

    // sweep of codes, misaligned starts and boundary lengths
    for (int c = 0; c < 8; c++)
      for (int ai = 0; ai < 8; ai++)
        for (int li = 0; li < 12; li++) begin
          tg++;
          run_req(addrs[ai], lens[li], c, tg, ai + li, p);
        end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule